// File: doc/BRIEF.md
# UART Receive Stuck-Zero Watchdog

This block watches the receive half of a UART receiver while it runs and flags a denial-of-service condition. On every clock edge it looks at two of the receiver's signals. One is the 3-bit receiver state. The other is the 8-bit received-byte output. A cycle is *suspicious* when the state holds the wait-for-sample code and the received byte is all zero at the same time. The block keeps a count of how many suspicious cycles have come back to back.

A run may last longer than the threshold allows. The threshold is an interval counted in cycles, and it is loaded while reset is held. When a run exceeds it, the block raises an alarm. The alarm stays up until the next reset. The integrating logic is expected to use the alarm to gate off, or lock, the monitored receiver. The live run length is also brought out so that the surrounding logic can observe how close the receiver is to tripping.

The property is tied to one receiver state. A zero byte seen in any other state, or a wait of any length while the byte is nonzero, never counts toward a trip. The block is therefore a temporal check and not a plain timeout.

Top module: `uwd_stuck_zero_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `run_count` = 0 and `alarm` = 0. The value on `threshold` at that edge is stored as the active threshold.
- R2: A suspicious cycle is one where `rx_state` equals 3'b011 and `rx_data` equals 8'h00. On such a cycle `run_count` rises by exactly one in the following cycle, as long as it is below its maximum.
- R3: A cycle that is not suspicious returns `run_count` to 0 in the following cycle. This holds whether the state differs from 3'b011, the byte is nonzero, or both.
- R4: `run_count` saturates at 2^CNT_W-1 and never wraps to zero during an unbroken run.
- R5: Let T be the stored threshold. `alarm` rises in the same cycle that `run_count` first shows T+2. This corresponds to a suspicious cycle arriving while `run_count` already exceeds T, meaning the run spans more than T cycles of interval.
- R6: With a stored threshold of 0, `alarm` rises after the second consecutive suspicious cycle and not after the first.
- R7: Once high, `alarm` stays high whatever `rx_state` and `rx_data` do, until `rst` is asserted.
- R8: Changes on `threshold` while `rst` is low have no effect. The alarm timing follows the value stored at reset.
- R9: A run of exactly T+1 suspicious cycles that is then broken does not raise `alarm`.
- R10: With a stored threshold of all ones, `alarm` never rises, even when `run_count` is saturated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also loads the threshold |
| rx_state | input | STATE_W (3) | Receiver state under observation |
| rx_data | input | DATA_W (8) | Receiver's received-byte output under observation |
| threshold | input | CNT_W (16) | Allowed interval in cycles, sampled while `rst` is high |
| alarm | output | 1 | Sticky violation flag, intended to lock the receiver |
| run_count | output | CNT_W (16) | Current number of consecutive suspicious cycles |

## Verification
The conditions hardest to reach from the ports are the two ends of the counter range. One is saturation with an all-ones threshold, where the count pins at its maximum and must still not trip the alarm. The other is the one-cycle margin between a run of T+1 cycles, which must stay quiet, and a run of T+2 cycles, which must trip. The bench uses a narrow counter so that the saturation point comes within a few dozen cycles, and it holds the suspicious pattern well past that point. It also builds runs of exactly T+1 and T+2 cycles and breaks them in separate ways: by state alone and by data alone. Finally, it moves the `threshold` input after reset, which shows that the stored value governs the alarm.

// File: rtl/uwd_pkg.sv
package uwd_pkg;

    // Receiver state code meaning "waiting for the sample point".
    localparam logic [2:0] UWD_WAIT_SAMPLE = 3'b011;

    // Received-byte value treated as a stuck output.
    localparam logic [7:0] UWD_STUCK_BYTE = 8'h00;

endpackage

// File: rtl/uwd_match_detect.sv
module uwd_match_detect #(
    parameter int unsigned           STATE_W   = 3,
    parameter int unsigned           DATA_W    = 8,
    parameter logic [STATE_W-1:0]    WAIT_CODE = STATE_W'(uwd_pkg::UWD_WAIT_SAMPLE),
    parameter logic [DATA_W-1:0]     STUCK_VAL = DATA_W'(uwd_pkg::UWD_STUCK_BYTE)
) (
    input  logic [STATE_W-1:0] rx_state,
    input  logic [DATA_W-1:0]  rx_data,
    output logic               suspicious
);

    logic state_hit;
    logic data_hit;

    always_comb begin
        state_hit  = (rx_state == WAIT_CODE);
        data_hit   = (rx_data  == STUCK_VAL);
        suspicious = state_hit & data_hit;
    end

endmodule

// File: rtl/uwd_run_counter.sv
module uwd_run_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspicious,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } run_state_t;

    run_state_t cnt_d;
    run_state_t cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!suspicious) begin
            cnt_d.run = '0;
        end else if (cnt_q.run != CNT_MAX) begin
            cnt_d.run = cnt_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.run;

endmodule

// File: rtl/uwd_alarm_latch.sv
module uwd_alarm_latch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] threshold,
    input  logic             suspicious,
    input  logic [CNT_W-1:0] count,
    output logic             alarm
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             tripped;
    } alarm_state_t;

    alarm_state_t alm_d;
    alarm_state_t alm_q;

    logic overlong;

    always_comb begin
        overlong = suspicious && (count > alm_q.limit);
        alm_d    = alm_q;
        if (rst) begin
            alm_d.limit   = threshold;
            alm_d.tripped = 1'b0;
        end else if (overlong) begin
            alm_d.tripped = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        alm_q <= alm_d;
    end

    assign alarm = alm_q.tripped;

endmodule

// File: rtl/uwd_stuck_zero_monitor.sv
module uwd_stuck_zero_monitor #(
    parameter int unsigned        STATE_W   = 3,
    parameter int unsigned        DATA_W    = 8,
    parameter int unsigned        CNT_W     = 16,
    parameter logic [STATE_W-1:0] WAIT_CODE = STATE_W'(uwd_pkg::UWD_WAIT_SAMPLE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] rx_state,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic [CNT_W-1:0]   threshold,
    output logic               alarm,
    output logic [CNT_W-1:0]   run_count
);

    logic suspicious;

    uwd_match_detect #(
        .STATE_W   (STATE_W),
        .DATA_W    (DATA_W),
        .WAIT_CODE (WAIT_CODE),
        .STUCK_VAL (DATA_W'(uwd_pkg::UWD_STUCK_BYTE))
    ) u_match (
        .rx_state   (rx_state),
        .rx_data    (rx_data),
        .suspicious (suspicious)
    );

    uwd_run_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .suspicious (suspicious),
        .count      (run_count)
    );

    uwd_alarm_latch #(
        .CNT_W (CNT_W)
    ) u_alarm (
        .clk        (clk),
        .rst        (rst),
        .threshold  (threshold),
        .suspicious (suspicious),
        .count      (run_count),
        .alarm      (alarm)
    );

endmodule

// File: rtl/uwd_stuck_zero_checker.sv
module uwd_stuck_zero_checker #(
    parameter int unsigned        STATE_W   = 3,
    parameter int unsigned        DATA_W    = 8,
    parameter int unsigned        CNT_W     = 16,
    parameter logic [STATE_W-1:0] WAIT_CODE = STATE_W'(uwd_pkg::UWD_WAIT_SAMPLE)
) (
    input logic               clk,
    input logic               rst,
    input logic [STATE_W-1:0] rx_state,
    input logic [DATA_W-1:0]  rx_data,
    input logic [CNT_W-1:0]   threshold,
    input logic               alarm,
    input logic [CNT_W-1:0]   run_count
);

    localparam logic [CNT_W-1:0] CK_MAX = {CNT_W{1'b1}};

    logic             hit;
    logic [CNT_W-1:0] thr_seen;

    assign hit = (rx_state == WAIT_CODE) && (rx_data == '0);

    // Checker's own copy of the threshold held at reset (R1, R8).
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_seen <= threshold;
        end
    end

    a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
        (hit && run_count != CK_MAX) |=> run_count == CNT_W'($past(run_count) + 1'b1));

    a_r3_clear_on_break: assert property (@(posedge clk) disable iff (rst)
        !hit |=> run_count == '0);

    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (hit && run_count == CK_MAX) |=> run_count == CK_MAX);

    a_r5_trip: assert property (@(posedge clk) disable iff (rst)
        (hit && run_count > thr_seen) |=> alarm);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        alarm |=> alarm);

    a_r9_no_early_trip: assert property (@(posedge clk) disable iff (rst)
        (!alarm && !(hit && run_count > thr_seen)) |=> !alarm);

endmodule

bind uwd_stuck_zero_monitor uwd_stuck_zero_checker #(
    .STATE_W   (STATE_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .WAIT_CODE (WAIT_CODE)
) u_uwd_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_state  (rx_state),
    .rx_data   (rx_data),
    .threshold (threshold),
    .alarm     (alarm),
    .run_count (run_count)
);

// File: tb/tb_uwd_stuck_zero_monitor.sv
module tb_uwd_stuck_zero_monitor;

    localparam int unsigned CW   = 6;
    localparam logic [CW-1:0] MAXC = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    rx_state = 3'b000;
    logic [7:0]    rx_data = 8'h00;
    logic [CW-1:0] threshold = '0;
    logic          alarm;
    logic [CW-1:0] run_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uwd_stuck_zero_monitor #(.STATE_W(3), .DATA_W(8), .CNT_W(CW)) dut (
        .clk       (clk),
        .rst       (rst),
        .rx_state  (rx_state),
        .rx_data   (rx_data),
        .threshold (threshold),
        .alarm     (alarm),
        .run_count (run_count)
    );

    typedef struct {
        logic [CW-1:0] cnt;
        logic          al;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    exp_t          cur;
    logic [CW-1:0] m_cnt = '0;
    logic          m_al  = 1'b0;
    logic [CW-1:0] m_thr = '0;

    // Driver: applies one vector per cycle and queues the expected outcome.
    task automatic drive(input logic r, input logic [2:0] s, input logic [7:0] d,
                         input logic [CW-1:0] t, input string tag);
        exp_t e;
        logic bad;
        @(negedge clk);
        rst = r; rx_state = s; rx_data = d; threshold = t;
        bad = (s == 3'b011) && (d == 8'h00);
        if (r) begin
            m_cnt = '0; m_al = 1'b0; m_thr = t;
        end else begin
            if (bad && m_cnt > m_thr) m_al = 1'b1;
            if (!bad) m_cnt = '0;
            else if (m_cnt != MAXC) m_cnt = m_cnt + 1'b1;
        end
        e.cnt = m_cnt; e.al = m_al; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic run_hits(input int n, input logic [CW-1:0] t, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 3'b011, 8'h00, t, tag);
    endtask

    // Monitor: compares outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (run_count !== cur.cnt || alarm !== cur.al) begin
                fails++;
                $display("FAIL %s: run_count=%0d alarm=%0b, expected run_count=%0d alarm=%0b",
                         cur.tag, run_count, alarm, cur.cnt, cur.al);
            end
        end
    end

    initial begin
        // R1: reset with threshold 3
        drive(1'b1, 3'b000, 8'h55, 6'd3, "R1");
        drive(1'b1, 3'b011, 8'h00, 6'd3, "R1");
        // R2 / R9: run of T+1 = 4, broken by state only
        run_hits(4, 6'd3, "R9");
        drive(1'b0, 3'b010, 8'h00, 6'd3, "R3");
        // R9: another run of 4, broken by data only
        run_hits(4, 6'd3, "R9");
        drive(1'b0, 3'b011, 8'h01, 6'd3, "R3");
        drive(1'b0, 3'b111, 8'hA5, 6'd3, "R3");
        // R8: threshold input moved to 0 after reset, stored 3 still rules
        run_hits(4, 6'd0, "R8");
        // R5: fifth cycle of the run trips (count shows T+2)
        run_hits(1, 6'd0, "R5");
        // R7: alarm holds through breaks
        drive(1'b0, 3'b000, 8'h00, 6'd0, "R7");
        drive(1'b0, 3'b011, 8'hFF, 6'd0, "R7");
        run_hits(2, 6'd0, "R7");
        // R1: reset clears alarm; threshold 0 stored
        drive(1'b1, 3'b011, 8'h00, 6'd0, "R1");
        // R6: first hit quiet, second trips
        run_hits(1, 6'd0, "R6");
        run_hits(1, 6'd0, "R6");
        drive(1'b0, 3'b001, 8'h00, 6'd0, "R7");
        // R10 / R4: all-ones threshold, saturate and stay quiet
        drive(1'b1, 3'b000, 8'h00, MAXC, "R1");
        run_hits(70, 6'd2, "R4");
        run_hits(3, 6'd2, "R10");
        drive(1'b0, 3'b100, 8'h00, 6'd2, "R3");
        // R1: plain reset once more
        drive(1'b1, 3'b011, 8'h00, 6'd5, "R1");
        run_hits(3, 6'd5, "R2");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule